// File: doc/BRIEF.md
# Audio Port Crossbar Switch

This block is a register-configured routing matrix for serial audio. It sits between a set of external audio ports (five by default) and a set of internal audio controllers (three by default). Every signal group is a lane of four wires: bit clock, frame sync and two serial data lines. Each port has a source selector. The selector takes one controller, another port, or nothing. The lane the port drives outward comes from that source. Each controller has three independent port selectors. The first picks the port whose bit clock and frame sync reach the controller. The other two pick the port for data line 1 and the port for data line 2.

Software programs the switch through a small 32-bit register bus with separate write and read strobes. Reads are registered. No consistency check is made. Several ports may follow one controller, which gives a broadcast. Two ports may both claim the master role. A port may even select itself. All of these are applied exactly as written. The routing paths are purely combinational from the stored configuration.

Top module: `axb_switch`

## Requirements
- R1: Port configuration words sit at byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10. Controller selector words sit at 0x40, 0x44 and 0x48. A write to any other offset, including an unaligned one, changes nothing. A read of any other offset returns zero.
- R2: A port word keeps bit 31 (master role), bit 30 (line 1 transmit), bit 29 (line 2 transmit) and bits 4:0 (source). A controller word keeps bits 3:0 (clock port), bits 27:24 (line 1 port) and bits 31:28 (line 2 port). All other bits read back as zero, so the read masks are 0xE000001F and 0xFF00000F.
- R3: Source values 0 to 2 connect the port's outgoing lane to controller 1 to 3. Values 16 to 20 connect it to the incoming lane of port 1 to 5. Self-selection is allowed.
- R4: The master role bit drives the port's clock and frame-sync output enable. It is applied as written, even when both sides of a link are master or neither is.
- R5: Each line-transmit bit drives the output enable of that data line of the port. The value 1 means transmit.
- R6: For a controller, clock-port value p (0 to 4) routes the bit clock and frame sync of port p+1 to the controller. The line 1 and line 2 selectors route the matching data line of their chosen ports on their own.
- R7: Any number of ports may select the same controller at once, and each of them carries that controller's lane. The controller's own inputs still follow only its selectors.
- R8: A port source outside 0 to 2 and 16 to 20 drives the port's outgoing lane low. A controller selector of 5 or above drives its wires low.
- R9: A write reaches the outputs only after the clock edge that accepts it. Read data appears on the edge that accepts the read and holds until the next read. A read and a write to the same word in one cycle return the old value.
- R10: After reset, port 1 selects controller 1 and port 3 selects controller 3. The other ports hold source 0x1F, which routes nothing. Controller n selects port n for all three signals. All role and transmit bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| port_bclk_i | input | NPORT | Bit clock arriving at each port |
| port_fsync_i | input | NPORT | Frame sync arriving at each port |
| port_sd1_i | input | NPORT | Data line 1 arriving at each port |
| port_sd2_i | input | NPORT | Data line 2 arriving at each port |
| port_bclk_o | output | NPORT | Bit clock sent out of each port |
| port_fsync_o | output | NPORT | Frame sync sent out of each port |
| port_sd1_o | output | NPORT | Data line 1 sent out of each port |
| port_sd2_o | output | NPORT | Data line 2 sent out of each port |
| port_clk_oe | output | NPORT | Clock and frame-sync drive enable (master role) |
| port_sd1_oe | output | NPORT | Data line 1 drive enable |
| port_sd2_oe | output | NPORT | Data line 2 drive enable |
| ctl_bclk_i | input | NCTL | Bit clock produced by each controller |
| ctl_fsync_i | input | NCTL | Frame sync produced by each controller |
| ctl_sd1_i | input | NCTL | Data line 1 produced by each controller |
| ctl_sd2_i | input | NCTL | Data line 2 produced by each controller |
| ctl_bclk_o | output | NCTL | Bit clock delivered to each controller |
| ctl_fsync_o | output | NCTL | Frame sync delivered to each controller |
| ctl_sd1_o | output | NCTL | Data line 1 delivered to each controller |
| ctl_sd2_o | output | NCTL | Data line 2 delivered to each controller |

## Verification
The only state is the stored configuration, and every routed wire is a combinational function of it. A corrupted field therefore shows at the ports in the first cycle after the write edge. It appears as a lane taken from the wrong source, an enable at the wrong level, or a wire held low. The bench sweeps several input patterns under each configuration, so a selector off by one shows up as a bit mismatch instead of staying hidden behind equal inputs. A wrong decode or mask shows on the next registered read, one edge after the read strobe.

// File: rtl/axb_pkg.sv
package axb_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int SRC_W  = 5;
    localparam int PSEL_W = 4;
    localparam int STRIDE = 4;

    localparam logic [ADDR_W-1:0] PORT_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] CTL_BASE  = 8'h40;

    localparam logic [SRC_W-1:0]  PEER_BASE = 5'd16;
    localparam logic [SRC_W-1:0]  SRC_IDLE  = 5'h1F;

    localparam int ROLE_BIT  = 31;
    localparam int TX1_BIT   = 30;
    localparam int TX2_BIT   = 29;
    localparam int CK_LSB    = 0;
    localparam int LN1_LSB   = 24;
    localparam int LN2_LSB   = 28;

    localparam logic [DATA_W-1:0] PORT_MASK = 32'hE000_001F;
    localparam logic [DATA_W-1:0] CTL_MASK  = 32'hFF00_000F;

    typedef struct packed {
        logic             master;
        logic             sd1_tx;
        logic             sd2_tx;
        logic [SRC_W-1:0] src;
    } port_cfg_t;

    typedef struct packed {
        logic [PSEL_W-1:0] sd2_sel;
        logic [PSEL_W-1:0] sd1_sel;
        logic [PSEL_W-1:0] clk_sel;
    } ctl_cfg_t;

    typedef struct packed {
        logic bclk;
        logic fsync;
        logic sd1;
        logic sd2;
    } lane_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CTL  = 2'd1,
        SRC_PEER = 2'd2
    } src_kind_e;

    function automatic logic [DATA_W-1:0] port_to_word(input port_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ROLE_BIT]      = c.master;
        w[TX1_BIT]       = c.sd1_tx;
        w[TX2_BIT]       = c.sd2_tx;
        w[SRC_W-1:0]     = c.src;
        return w;
    endfunction

    function automatic port_cfg_t word_to_port(input logic [DATA_W-1:0] w);
        port_cfg_t c;
        c.master = w[ROLE_BIT];
        c.sd1_tx = w[TX1_BIT];
        c.sd2_tx = w[TX2_BIT];
        c.src    = w[SRC_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CK_LSB  +: PSEL_W] = c.clk_sel;
        w[LN1_LSB +: PSEL_W] = c.sd1_sel;
        w[LN2_LSB +: PSEL_W] = c.sd2_sel;
        return w;
    endfunction

    function automatic ctl_cfg_t word_to_ctl(input logic [DATA_W-1:0] w);
        ctl_cfg_t c;
        c.clk_sel = w[CK_LSB  +: PSEL_W];
        c.sd1_sel = w[LN1_LSB +: PSEL_W];
        c.sd2_sel = w[LN2_LSB +: PSEL_W];
        return c;
    endfunction

endpackage

// File: rtl/axb_regs.sv
module axb_regs
    import axb_pkg::*;
#(
    parameter int               NPORT    = 5,
    parameter int               NCTL     = 3,
    parameter logic [NPORT-1:0] RST_LINK = 5'b00101
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output port_cfg_t [NPORT-1:0]     port_cfg,
    output ctl_cfg_t  [NCTL-1:0]      ctl_cfg
);

    port_cfg_t [NPORT-1:0] port_q;
    ctl_cfg_t  [NCTL-1:0]  ctl_q;
    logic      [NPORT-1:0] port_hit;
    logic      [NCTL-1:0]  ctl_hit;
    logic      [DATA_W-1:0] rd_word;

    function automatic port_cfg_t port_reset(input int k);
        port_cfg_t c;
        c.master = 1'b0;
        c.sd1_tx = 1'b0;
        c.sd2_tx = 1'b0;
        c.src    = RST_LINK[k] ? SRC_W'(k) : SRC_IDLE;
        return c;
    endfunction

    function automatic ctl_cfg_t ctl_reset(input int j);
        ctl_cfg_t c;
        c.clk_sel = PSEL_W'(j);
        c.sd1_sel = PSEL_W'(j);
        c.sd2_sel = PSEL_W'(j);
        return c;
    endfunction

    always_comb begin
        for (int k = 0; k < NPORT; k++) begin
            port_hit[k] = (bus_addr == PORT_BASE + ADDR_W'(k * STRIDE));
        end
        for (int j = 0; j < NCTL; j++) begin
            ctl_hit[j] = (bus_addr == CTL_BASE + ADDR_W'(j * STRIDE));
        end
    end

    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (port_hit[k]) rd_word = rd_word | port_to_word(port_q[k]);
        end
        for (int j = 0; j < NCTL; j++) begin
            if (ctl_hit[j]) rd_word = rd_word | ctl_to_word(ctl_q[j]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NPORT; k++) port_q[k] <= port_reset(k);
            for (int j = 0; j < NCTL; j++)  ctl_q[j]  <= ctl_reset(j);
            bus_rdata <= '0;
        end else begin
            if (bus_wr) begin
                for (int k = 0; k < NPORT; k++) begin
                    if (port_hit[k]) port_q[k] <= word_to_port(bus_wdata);
                end
                for (int j = 0; j < NCTL; j++) begin
                    if (ctl_hit[j]) ctl_q[j] <= word_to_ctl(bus_wdata);
                end
            end
            if (bus_rd) bus_rdata <= rd_word;
        end
    end

    assign port_cfg = port_q;
    assign ctl_cfg  = ctl_q;

    // R9: an accepted port write is visible, masked, after the edge
    for (genvar k = 0; k < NPORT; k++) begin : g_port_chk
        a_r9_port_commit: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == PORT_BASE + ADDR_W'(k * STRIDE))
            |=> (port_to_word(port_q[k]) == ($past(bus_wdata) & PORT_MASK)));
    end

    // R9: an accepted controller write is visible, masked, after the edge
    for (genvar j = 0; j < NCTL; j++) begin : g_ctl_chk
        a_r9_ctl_commit: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == CTL_BASE + ADDR_W'(j * STRIDE))
            |=> (ctl_to_word(ctl_q[j]) == ($past(bus_wdata) & CTL_MASK)));
    end

    // R1: writes to undecoded offsets leave every word unchanged
    a_r1_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && port_hit == '0 && ctl_hit == '0)
        |=> ($stable(port_q) && $stable(ctl_q)));

    // R1: reads of undecoded offsets return zero
    a_r1_stray_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && port_hit == '0 && ctl_hit == '0) |=> (bus_rdata == '0));

    // R9: read data holds between reads
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/axb_port_mux.sv
module axb_port_mux
    import axb_pkg::*;
#(
    parameter int NPORT = 5,
    parameter int NCTL  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  port_cfg_t             cfg,
    input  lane_t [NCTL-1:0]      ctl_lanes,
    input  lane_t [NPORT-1:0]     peer_lanes,
    output lane_t                 lane_o,
    output logic                  clk_oe,
    output logic                  sd1_oe,
    output logic                  sd2_oe
);

    src_kind_e kind;
    lane_t     ctl_pick;
    lane_t     peer_pick;

    always_comb begin
        kind      = SRC_NONE;
        ctl_pick  = '0;
        peer_pick = '0;
        for (int c = 0; c < NCTL; c++) begin
            if (cfg.src == SRC_W'(c)) begin
                kind     = SRC_CTL;
                ctl_pick = ctl_lanes[c];
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            if (cfg.src == PEER_BASE + SRC_W'(p)) begin
                kind      = SRC_PEER;
                peer_pick = peer_lanes[p];
            end
        end
    end

    always_comb begin
        unique case (kind)
            SRC_CTL:  lane_o = ctl_pick;
            SRC_PEER: lane_o = peer_pick;
            default:  lane_o = '0;
        endcase
    end

    assign clk_oe = cfg.master;
    assign sd1_oe = cfg.sd1_tx;
    assign sd2_oe = cfg.sd2_tx;

    // R8: an undefined source value leaves the outgoing lane low
    a_r8_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src >= SRC_W'(NCTL) &&
         !(cfg.src >= PEER_BASE && cfg.src < PEER_BASE + SRC_W'(NPORT)))
        |-> (lane_o == '0));

endmodule

// File: rtl/axb_ctl_mux.sv
module axb_ctl_mux
    import axb_pkg::*;
#(
    parameter int NPORT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_cfg_t          cfg,
    input  lane_t [NPORT-1:0] port_lanes,
    output lane_t             lane_o
);

    always_comb begin
        lane_o = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (cfg.clk_sel == PSEL_W'(p)) begin
                lane_o.bclk  = port_lanes[p].bclk;
                lane_o.fsync = port_lanes[p].fsync;
            end
            if (cfg.sd1_sel == PSEL_W'(p)) lane_o.sd1 = port_lanes[p].sd1;
            if (cfg.sd2_sel == PSEL_W'(p)) lane_o.sd2 = port_lanes[p].sd2;
        end
    end

    // R8: an out-of-range clock selector keeps clock and frame sync low
    a_r8_ctl_clk_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.clk_sel >= PSEL_W'(NPORT)) |-> (!lane_o.bclk && !lane_o.fsync));

    // R8: out-of-range data selectors keep their lines low
    a_r8_ctl_data_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.sd1_sel >= PSEL_W'(NPORT)) |-> !lane_o.sd1) and
        ((cfg.sd2_sel >= PSEL_W'(NPORT)) |-> !lane_o.sd2));

endmodule

// File: rtl/axb_switch.sv
module axb_switch
    import axb_pkg::*;
#(
    parameter int               NPORT    = 5,
    parameter int               NCTL     = 3,
    parameter logic [NPORT-1:0] RST_LINK = 5'b00101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPORT-1:0]  port_bclk_i,
    input  logic [NPORT-1:0]  port_fsync_i,
    input  logic [NPORT-1:0]  port_sd1_i,
    input  logic [NPORT-1:0]  port_sd2_i,
    output logic [NPORT-1:0]  port_bclk_o,
    output logic [NPORT-1:0]  port_fsync_o,
    output logic [NPORT-1:0]  port_sd1_o,
    output logic [NPORT-1:0]  port_sd2_o,
    output logic [NPORT-1:0]  port_clk_oe,
    output logic [NPORT-1:0]  port_sd1_oe,
    output logic [NPORT-1:0]  port_sd2_oe,
    input  logic [NCTL-1:0]   ctl_bclk_i,
    input  logic [NCTL-1:0]   ctl_fsync_i,
    input  logic [NCTL-1:0]   ctl_sd1_i,
    input  logic [NCTL-1:0]   ctl_sd2_i,
    output logic [NCTL-1:0]   ctl_bclk_o,
    output logic [NCTL-1:0]   ctl_fsync_o,
    output logic [NCTL-1:0]   ctl_sd1_o,
    output logic [NCTL-1:0]   ctl_sd2_o
);

    port_cfg_t [NPORT-1:0] port_cfg;
    ctl_cfg_t  [NCTL-1:0]  ctl_cfg;
    lane_t     [NPORT-1:0] port_in_l;
    lane_t     [NPORT-1:0] port_out_l;
    lane_t     [NCTL-1:0]  ctl_in_l;
    lane_t     [NCTL-1:0]  ctl_out_l;

    axb_regs #(
        .NPORT    (NPORT),
        .NCTL     (NCTL),
        .RST_LINK (RST_LINK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_cfg  (port_cfg),
        .ctl_cfg   (ctl_cfg)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign port_in_l[p] = {port_bclk_i[p], port_fsync_i[p],
                               port_sd1_i[p], port_sd2_i[p]};

        axb_port_mux #(
            .NPORT (NPORT),
            .NCTL  (NCTL)
        ) u_pmux (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (port_cfg[p]),
            .ctl_lanes  (ctl_in_l),
            .peer_lanes (port_in_l),
            .lane_o     (port_out_l[p]),
            .clk_oe     (port_clk_oe[p]),
            .sd1_oe     (port_sd1_oe[p]),
            .sd2_oe     (port_sd2_oe[p])
        );

        assign port_bclk_o[p]  = port_out_l[p].bclk;
        assign port_fsync_o[p] = port_out_l[p].fsync;
        assign port_sd1_o[p]   = port_out_l[p].sd1;
        assign port_sd2_o[p]   = port_out_l[p].sd2;
    end

    for (genvar c = 0; c < NCTL; c++) begin : g_ctl
        assign ctl_in_l[c] = {ctl_bclk_i[c], ctl_fsync_i[c],
                              ctl_sd1_i[c], ctl_sd2_i[c]};

        axb_ctl_mux #(
            .NPORT (NPORT)
        ) u_cmux (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg        (ctl_cfg[c]),
            .port_lanes (port_in_l),
            .lane_o     (ctl_out_l[c])
        );

        assign ctl_bclk_o[c]  = ctl_out_l[c].bclk;
        assign ctl_fsync_o[c] = ctl_out_l[c].fsync;
        assign ctl_sd1_o[c]   = ctl_out_l[c].sd1;
        assign ctl_sd2_o[c]   = ctl_out_l[c].sd2;
    end

endmodule

// File: tb/sim_axb_switch.sv
module sim_axb_switch;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  pb = '0, pf = '0, p1 = '0, p2 = '0;
    logic [4:0]  pbo, pfo, p1o, p2o, pco, p1e, p2e;
    logic [2:0]  cb = '0, cf = '0, c1 = '0, c2 = '0;
    logic [2:0]  cbo, cfo, c1o, c2o;

    logic [31:0] pw [5];
    logic [31:0] cw [3];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axb_switch u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_bclk_i(pb), .port_fsync_i(pf), .port_sd1_i(p1), .port_sd2_i(p2),
        .port_bclk_o(pbo), .port_fsync_o(pfo), .port_sd1_o(p1o), .port_sd2_o(p2o),
        .port_clk_oe(pco), .port_sd1_oe(p1e), .port_sd2_oe(p2e),
        .ctl_bclk_i(cb), .ctl_fsync_i(cf), .ctl_sd1_i(c1), .ctl_sd2_i(c2),
        .ctl_bclk_o(cbo), .ctl_fsync_o(cfo), .ctl_sd1_o(c1o), .ctl_sd2_o(c2o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_pattern(input int seed);
        logic [31:0] a;
        logic [31:0] b;
        a = 32'(seed) * 32'h9E37 ^ 32'h5A5A3C;
        b = 32'(seed) * 32'h03B1 ^ 32'h0C3F;
        {pb, pf, p1, p2} = a[19:0];
        {cb, cf, c1, c2} = b[11:0];
        #1;
    endtask

    task automatic check_outputs(input string req);
        logic [4:0] eb, ef, e1, e2, eoc, eo1, eo2;
        logic [2:0] xb, xf, x1, x2;
        eb = '0; ef = '0; e1 = '0; e2 = '0;
        xb = '0; xf = '0; x1 = '0; x2 = '0;
        for (int i = 0; i < 5; i++) begin
            int s;
            s = int'(pw[i][4:0]);
            if (s < 3) begin
                eb[i] = cb[s]; ef[i] = cf[s]; e1[i] = c1[s]; e2[i] = c2[s];
            end else if (s >= 16 && s <= 20) begin
                eb[i] = pb[s-16]; ef[i] = pf[s-16]; e1[i] = p1[s-16]; e2[i] = p2[s-16];
            end
            eoc[i] = pw[i][31];
            eo1[i] = pw[i][30];
            eo2[i] = pw[i][29];
        end
        for (int j = 0; j < 3; j++) begin
            int k, s1, s2;
            k  = int'(cw[j][3:0]);
            s1 = int'(cw[j][27:24]);
            s2 = int'(cw[j][31:28]);
            if (k < 5)  begin xb[j] = pb[k]; xf[j] = pf[k]; end
            if (s1 < 5) x1[j] = p1[s1];
            if (s2 < 5) x2[j] = p2[s2];
        end
        chk(req, "port_bclk_o",  32'(pbo), 32'(eb));
        chk(req, "port_fsync_o", 32'(pfo), 32'(ef));
        chk(req, "port_sd1_o",   32'(p1o), 32'(e1));
        chk(req, "port_sd2_o",   32'(p2o), 32'(e2));
        chk(req, "port_clk_oe",  32'(pco), 32'(eoc));
        chk(req, "port_sd1_oe",  32'(p1e), 32'(eo1));
        chk(req, "port_sd2_oe",  32'(p2e), 32'(eo2));
        chk(req, "ctl_bclk_o",   32'(cbo), 32'(xb));
        chk(req, "ctl_fsync_o",  32'(cfo), 32'(xf));
        chk(req, "ctl_sd1_o",    32'(c1o), 32'(x1));
        chk(req, "ctl_sd2_o",    32'(c2o), 32'(x2));
    endtask

    task automatic sweep(input string req, input int base);
        for (int s = 0; s < 4; s++) begin
            set_pattern(base + s);
            check_outputs(req);
        end
    endtask

    task automatic shadow_write(input logic [7:0] a, input logic [31:0] d);
        if (a[1:0] == 2'b00 && a <= 8'h10) pw[a >> 2] = d & 32'hE000_001F;
        if (a[1:0] == 2'b00 && a >= 8'h40 && a <= 8'h48) cw[(a - 8'h40) >> 2] = d & 32'hFF00_000F;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        shadow_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        pw[0] = 32'h0; pw[1] = 32'h1F; pw[2] = 32'h2; pw[3] = 32'h1F; pw[4] = 32'h1F;
        cw[0] = 32'h0; cw[1] = 32'h1100_0001; cw[2] = 32'h2200_0002;
        chk("R10", "rdata after reset", bus_rdata, 32'h0);
        for (int i = 0; i < 5; i++) begin
            rd(8'(4*i), d);
            chk("R10", "port word reset", d, pw[i]);
        end
        for (int j = 0; j < 3; j++) begin
            rd(8'h40 + 8'(4*j), d);
            chk("R10", "ctl word reset", d, cw[j]);
        end
        sweep("R10", 1);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        for (int i = 0; i < 5; i++) wr(8'(4*i), 32'hFFFF_FFFF);
        for (int j = 0; j < 3; j++) wr(8'h40 + 8'(4*j), 32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) begin
            rd(8'(4*i), d);
            chk("R2", "port word mask", d, 32'hE000_001F);
        end
        for (int j = 0; j < 3; j++) begin
            rd(8'h40 + 8'(4*j), d);
            chk("R2", "ctl word mask", d, 32'hFF00_000F);
        end
        for (int i = 0; i < 5; i++) wr(8'(4*i), 32'h1000_0000 | 32'(i));
        for (int j = 0; j < 3; j++) wr(8'h40 + 8'(4*j), 32'h0000_0000);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h4C, 32'hFFFF_FFFF);
        wr(8'h41, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        for (int i = 0; i < 5; i++) begin
            rd(8'(4*i), d);
            chk("R1", "port word after stray writes", d, pw[i]);
        end
        for (int j = 0; j < 3; j++) begin
            rd(8'h40 + 8'(4*j), d);
            chk("R1", "ctl word after stray writes", d, cw[j]);
        end
        rd(8'h14, d); chk("R1", "read 0x14", d, 32'h0);
        rd(8'h41, d); chk("R1", "read 0x41", d, 32'h0);
        rd(8'hFC, d); chk("R1", "read 0xFC", d, 32'h0);
        sweep("R1", 10);
    endtask

    task automatic t_port_ctl;
        for (int i = 0; i < 5; i++) wr(8'(4*i), 32'((i + 1) % 3));
        sweep("R3", 20);
    endtask

    task automatic t_peer;
        wr(8'h00, 32'd20);
        wr(8'h04, 32'd16);
        wr(8'h08, 32'd18);
        wr(8'h0C, 32'd19);
        wr(8'h10, 32'd17);
        sweep("R3", 30);
    endtask

    task automatic t_roles;
        wr(8'h00, 32'h8000_0011);
        wr(8'h04, 32'h8000_0010);
        wr(8'h08, 32'h0000_0013);
        wr(8'h0C, 32'h0000_0012);
        sweep("R4", 40);
        chk("R4", "both masters", 32'(pco[1:0]), 32'h3);
        chk("R4", "neither master", 32'(pco[3:2]), 32'h0);
    endtask

    task automatic t_dirs;
        wr(8'h00, 32'h4000_0000);
        wr(8'h04, 32'h2000_0001);
        wr(8'h08, 32'h6000_0002);
        wr(8'h0C, 32'hE000_0010);
        sweep("R5", 50);
    endtask

    task automatic t_ctl_sel;
        wr(8'h40, 32'h2000_0004);
        wr(8'h44, 32'h0300_0001);
        wr(8'h48, 32'h4100_0003);
        sweep("R6", 60);
    endtask

    task automatic t_broadcast;
        for (int i = 0; i < 5; i++) wr(8'(4*i), 32'h0000_0001);
        wr(8'h44, 32'h3200_0004);
        for (int s = 0; s < 4; s++) begin
            set_pattern(70 + s);
            check_outputs("R7");
            chk("R7", "all ports carry ctl2 clock", 32'(pbo), {27'd0, {5{cb[1]}}});
        end
    endtask

    task automatic t_invalid;
        wr(8'h00, 32'd3);
        wr(8'h04, 32'd15);
        wr(8'h08, 32'd21);
        wr(8'h0C, 32'd31);
        wr(8'h10, 32'd8);
        wr(8'h40, 32'h5F00_0005);
        wr(8'h44, 32'hF600_000F);
        wr(8'h48, 32'h0700_0002);
        for (int s = 0; s < 4; s++) begin
            set_pattern(80 + s);
            check_outputs("R8");
        end
        pb = '1; pf = '1; p1 = '1; p2 = '1; cb = '1; cf = '1; c1 = '1; c2 = '1;
        #1;
        check_outputs("R8");
        chk("R8", "port lanes low with all inputs high", 32'({pbo, pfo, p1o, p2o}), 32'h0);
    endtask

    task automatic t_timing;
        logic [31:0] d;
        wr(8'h00, 32'h0000_0000);
        set_pattern(90);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h8000_0011;
        #1;
        check_outputs("R9");
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R9", "read beside write returns old", bus_rdata, 32'h0);
        shadow_write(8'h00, 32'h8000_0011);
        check_outputs("R9");
        rd(8'h00, d);
        chk("R9", "later read returns new", d, 32'h8000_0011);
        repeat (3) @(negedge clk);
        chk("R9", "rdata holds without read", bus_rdata, 32'h8000_0011);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_port_ctl();
        t_peer();
        t_roles();
        t_dirs();
        t_ctl_sel();
        t_broadcast();
        t_invalid();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule